// File: doc/BRIEF.md
# Cache-Block Management Instruction Decoder

This block inspects a 32-bit instruction word and picks out the three cache-block management operations: clean, flush and invalidate. For a word it recognises, it checks the machine-level and supervisor-level enable fields against the current privilege level. It then reports one of two outcomes: a legal operation, given as a one-hot code together with the source register index, or an illegal-instruction flag. An invalidate that is permitted, but not permitted to discard data, is quietly issued as a flush.

The decode is purely combinational. A parameter can add one register stage on the outputs. Each cycle, a word is offered with `in_valid` and is always accepted; the block has no back-pressure, so there is no ready signal. The consumer sees the result as a single-cycle `out_valid` or `out_illegal` pulse. The pulse appears in the same cycle when `REG_OUT` is 0, and one clock later when it is 1 (the default).

Top module: `cbo_decoder`

## Requirements
- R1: A word is recognised only when bits [6:0] equal 7'b0001111, bits [14:12] equal 3'b010 and bits [11:7] equal 5'b00000. Any other word produces neither `out_valid` nor `out_illegal`.
- R2: Bits [31:20] select the operation: 12'h001 is clean, 12'h002 is flush and 12'h000 is invalidate. Any other selector value produces neither `out_valid` nor `out_illegal`.
- R3: While `ext_en` is low, no word is recognised, and both `out_valid` and `out_illegal` stay low.
- R4: Clean and flush are legal only when the clean/flush enable resolves true for the current privilege. Otherwise `out_illegal` is raised.
- R5: Invalidate is legal only when bit 0 of the invalidate field resolves true for the current privilege. Otherwise `out_illegal` is raised.
- R6: When invalidate is legal but bit 1 of the invalidate field resolves false, the operation is reported as flush instead of invalidate.
- R7: An enable bit resolves per privilege as follows. With `priv` = 2'b11 (machine) it is always true. With 2'b01 (supervisor) it uses the machine-level bit. With 2'b00 (user) it needs both the machine-level and the supervisor-level bits. The reserved value 2'b10 makes every recognised operation illegal.
- R8: `out_op` is one-hot (bit 0 clean, bit 1 flush, bit 2 invalidate) when `out_valid` is high and all-zero otherwise. `out_valid` and `out_illegal` are never high together.
- R9: `out_rs1` carries instruction bits [19:15] when `out_valid` is high and is zero otherwise.
- R10: With `REG_OUT` = 1, results appear one clock after the inputs. Reset clears every output. A cycle with `in_valid` low yields no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Enables recognition of the operation group |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| priv | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| m_cf_en | input | 1 | Machine-level clean/flush enable |
| m_inv_en | input | 2 | Machine-level invalidate field (bit 0 allow, bit 1 true invalidate) |
| s_cf_en | input | 1 | Supervisor-level clean/flush enable |
| s_inv_en | input | 2 | Supervisor-level invalidate field |
| out_valid | output | 1 | Legal operation decoded |
| out_op | output | 3 | One-hot operation: clean, flush, invalidate |
| out_rs1 | output | 5 | Source register index |
| out_illegal | output | 1 | Recognised operation not permitted |

## Verification
Random words are drawn mostly in the recognised format, with selectors from the legal set and from outside it. This separates the R2 selector decode from the R1 fixed-field match, and each corrupted fixed field is tried alone. All four privilege codes are crossed with every combination of the six enable bits. This shows the user/supervisor/machine resolution and the reserved code as distinct outcomes, and it separates a downgrade to flush from a plain illegal invalidate. Directed cases cover `ext_en` low, `in_valid` low, and a word that is correct except for one bit of rd.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
  localparam int INSTR_W = 32;
  localparam int RIDX_W  = 5;
  localparam int SEL_W   = 12;
  localparam int OP_W    = 3;
  localparam int LANES   = 3;   // enable lanes: clean/flush, inval allow, inval keep

  localparam logic [6:0]       MATCH_OPC   = 7'b0001111;
  localparam logic [2:0]       MATCH_F3    = 3'b010;
  localparam logic [4:0]       MATCH_RD    = 5'b00000;
  localparam logic [SEL_W-1:0] SEL_CLEAN   = 12'h001;
  localparam logic [SEL_W-1:0] SEL_FLUSH   = 12'h002;
  localparam logic [SEL_W-1:0] SEL_INVAL   = 12'h000;

  localparam int OPB_CLEAN = 0;
  localparam int OPB_FLUSH = 1;
  localparam int OPB_INVAL = 2;

  localparam int LANE_CF   = 0;
  localparam int LANE_IALW = 1;
  localparam int LANE_IKEEP = 2;

  typedef enum logic [1:0] {
    PRIV_USER = 2'b00,
    PRIV_SUP  = 2'b01,
    PRIV_RSV  = 2'b10,
    PRIV_MACH = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_CLEAN,
    KIND_FLUSH,
    KIND_INVAL
  } kind_e;

  typedef struct packed {
    logic              valid;
    logic              illegal;
    logic [OP_W-1:0]   op;
    logic [RIDX_W-1:0] rs1;
  } cbo_res_t;
endpackage

// File: rtl/cbo_field_decode.sv
module cbo_field_decode
  import cbo_pkg::*;
(
  input  logic               ext_en,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  output kind_e              kind,
  output logic [RIDX_W-1:0]  rs1
);
  logic fmt_hit;
  logic [SEL_W-1:0] sel;

  assign sel     = instr[31:20];
  assign rs1     = instr[19:15];
  assign fmt_hit = ext_en && in_valid &&
                   (instr[6:0] == MATCH_OPC) &&
                   (instr[14:12] == MATCH_F3) &&
                   (instr[11:7] == MATCH_RD);

  always_comb begin
    kind = KIND_NONE;
    if (fmt_hit) begin
      unique case (sel)
        SEL_CLEAN: kind = KIND_CLEAN;
        SEL_FLUSH: kind = KIND_FLUSH;
        SEL_INVAL: kind = KIND_INVAL;
        default:   kind = KIND_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cbo_priv_gate.sv
module cbo_priv_gate
  import cbo_pkg::*;
(
  input  priv_e priv,
  input  logic  m_bit,
  input  logic  s_bit,
  output logic  en
);
  always_comb begin
    unique case (priv)
      PRIV_MACH: en = 1'b1;
      PRIV_SUP:  en = m_bit;
      PRIV_USER: en = m_bit & s_bit;
      default:   en = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbo_out_stage.sv
module cbo_out_stage
  import cbo_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cbo_res_t d,
  output cbo_res_t q
);
  generate
    if (REG_OUT) begin : g_reg
      cbo_res_t q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
      end
      assign q = q_r;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/cbo_decoder.sv
module cbo_decoder
  import cbo_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_en,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [1:0]  priv,
  input  logic        m_cf_en,
  input  logic [1:0]  m_inv_en,
  input  logic        s_cf_en,
  input  logic [1:0]  s_inv_en,
  output logic        out_valid,
  output logic [2:0]  out_op,
  output logic [4:0]  out_rs1,
  output logic        out_illegal
);
  kind_e             kind;
  logic [RIDX_W-1:0] rs1_f;
  logic [LANES-1:0]  m_bits, s_bits, lane_en;
  priv_e             priv_q;
  cbo_res_t          res_d, res_q;

  assign priv_q = priv_e'(priv);
  assign m_bits = {m_inv_en[1], m_inv_en[0], m_cf_en};
  assign s_bits = {s_inv_en[1], s_inv_en[0], s_cf_en};

  cbo_field_decode u_fields (
    .ext_en  (ext_en),
    .in_valid(in_valid),
    .instr   (instr),
    .kind    (kind),
    .rs1     (rs1_f)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      cbo_priv_gate u_gate (
        .priv (priv_q),
        .m_bit(m_bits[g]),
        .s_bit(s_bits[g]),
        .en   (lane_en[g])
      );
    end
  endgenerate

  always_comb begin
    res_d = '0;
    unique case (kind)
      KIND_CLEAN, KIND_FLUSH: begin
        if (lane_en[LANE_CF]) begin
          res_d.valid = 1'b1;
          res_d.op[(kind == KIND_CLEAN) ? OPB_CLEAN : OPB_FLUSH] = 1'b1;
        end else begin
          res_d.illegal = 1'b1;
        end
      end
      KIND_INVAL: begin
        if (lane_en[LANE_IALW]) begin
          res_d.valid = 1'b1;
          res_d.op[lane_en[LANE_IKEEP] ? OPB_INVAL : OPB_FLUSH] = 1'b1;
        end else begin
          res_d.illegal = 1'b1;
        end
      end
      default: res_d = '0;
    endcase
    if (res_d.valid) res_d.rs1 = rs1_f;
  end

  cbo_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (res_d),
    .q    (res_q)
  );

  assign out_valid   = res_q.valid;
  assign out_illegal = res_q.illegal;
  assign out_op      = res_q.op;
  assign out_rs1     = res_q.rs1;
endmodule

// File: rtl/cbo_decoder_chk.sv
module cbo_decoder_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_en,
  input logic        in_valid,
  input logic [1:0]  priv,
  input logic        out_valid,
  input logic [2:0]  out_op,
  input logic [4:0]  out_rs1,
  input logic        out_illegal
);
  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));
  assert_op_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_op) == 1);
  assert_op_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_op == 3'b000);
  assert_rs1_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_rs1 == 5'd0);

  generate
    if (REG_OUT) begin : g_seq
      assert_no_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(out_valid || out_illegal));
      assert_ext_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |=> !(out_valid || out_illegal));
      assert_rsv_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        priv == 2'b10 |=> !out_valid);
    end else begin : g_cmb
      assert_no_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !(out_valid || out_illegal));
      assert_ext_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |-> !(out_valid || out_illegal));
      assert_rsv_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        priv == 2'b10 |-> !out_valid);
    end
  endgenerate
endmodule

bind cbo_decoder cbo_decoder_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_en     (ext_en),
  .in_valid   (in_valid),
  .priv       (priv),
  .out_valid  (out_valid),
  .out_op     (out_op),
  .out_rs1    (out_rs1),
  .out_illegal(out_illegal)
);

// File: tb/tb_cbo_decoder.sv
module tb_cbo_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_en = 1'b0, in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [1:0]  priv = 2'b11;
  logic        m_cf_en = 1'b0, s_cf_en = 1'b0;
  logic [1:0]  m_inv_en = '0, s_inv_en = '0;
  logic        out_valid, out_illegal;
  logic [2:0]  out_op;
  logic [4:0]  out_rs1;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cbo_decoder #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .in_valid(in_valid),
    .instr(instr), .priv(priv), .m_cf_en(m_cf_en), .m_inv_en(m_inv_en),
    .s_cf_en(s_cf_en), .s_inv_en(s_inv_en), .out_valid(out_valid),
    .out_op(out_op), .out_rs1(out_rs1), .out_illegal(out_illegal)
  );

  // Resolve one enable bit per R7.
  function automatic bit resolve(input logic [1:0] p, input bit mb, input bit sb);
    case (p)
      2'b11:   return 1'b1;
      2'b01:   return mb;
      2'b00:   return mb & sb;
      default: return 1'b0;
    endcase
  endfunction

  // Expected {valid, illegal, op[2:0], rs1[4:0]}
  function automatic logic [9:0] model(input bit ex, input bit iv, input logic [31:0] w,
                                       input logic [1:0] p, input bit mcf, input logic [1:0] mie,
                                       input bit scf, input logic [1:0] sie);
    bit hit = ex && iv && w[6:0] == 7'b0001111 && w[14:12] == 3'b010 && w[11:7] == 5'd0;
    if (!hit) return '0;
    if (w[31:20] == 12'h001 || w[31:20] == 12'h002) begin
      if (!resolve(p, mcf, scf)) return 10'b01_000_00000;
      return {2'b10, (w[31:20] == 12'h001) ? 3'b001 : 3'b010, w[19:15]};
    end
    if (w[31:20] == 12'h000) begin
      if (!resolve(p, mie[0], sie[0])) return 10'b01_000_00000;
      return {2'b10, resolve(p, mie[1], sie[1]) ? 3'b100 : 3'b010, w[19:15]};
    end
    return '0;
  endfunction

  function automatic logic [31:0] mk(input logic [11:0] sel, input logic [4:0] r);
    return {sel, r, 3'b010, 5'b00000, 7'b0001111};
  endfunction

  task automatic check(input string tag, input logic [9:0] exp);
    logic [9:0] act = {out_valid, out_illegal, out_op, out_rs1};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual v=%b i=%b op=%b rs1=%0d expected v=%b i=%b op=%b rs1=%0d",
               tag, act[9], act[8], act[7:5], act[4:0], exp[9], exp[8], exp[7:5], exp[4:0]);
    end
  endtask

  task automatic apply(input string tag, input bit ex, input bit iv, input logic [31:0] w,
                       input logic [1:0] p, input bit mcf, input logic [1:0] mie,
                       input bit scf, input logic [1:0] sie);
    logic [9:0] exp = model(ex, iv, w, p, mcf, mie, scf, sie);
    @(negedge clk);
    ext_en = ex; in_valid = iv; instr = w; priv = p;
    m_cf_en = mcf; m_inv_en = mie; s_cf_en = scf; s_inv_en = sie;
    @(posedge clk); #2;  // R10: registered result one clock later
    check(tag, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_C0DE));
    repeat (3) @(posedge clk);
    #2 check("R10 reset", '0);
    @(negedge clk) rst_n = 1'b1;

    // Directed corners
    apply("R2 clean M", 1, 1, mk(12'h001, 5'd7), 2'b11, 0, 2'b00, 0, 2'b00);
    apply("R2 flush M", 1, 1, mk(12'h002, 5'd31), 2'b11, 0, 2'b00, 0, 2'b00);
    apply("R6 inval M", 1, 1, mk(12'h000, 5'd3), 2'b11, 0, 2'b00, 0, 2'b00);
    apply("R2 bad sel", 1, 1, mk(12'h003, 5'd3), 2'b11, 1, 2'b11, 1, 2'b11);
    apply("R1 rd bit", 1, 1, mk(12'h001, 5'd3) | 32'h80, 2'b11, 1, 2'b11, 1, 2'b11);
    apply("R1 funct3", 1, 1, mk(12'h001, 5'd3) ^ 32'h1000, 2'b11, 1, 2'b11, 1, 2'b11);
    apply("R1 opcode", 1, 1, mk(12'h002, 5'd3) ^ 32'h1, 2'b11, 1, 2'b11, 1, 2'b11);
    apply("R3 ext off", 0, 1, mk(12'h001, 5'd9), 2'b11, 1, 2'b11, 1, 2'b11);
    apply("R10 no in_valid", 1, 0, mk(12'h001, 5'd9), 2'b11, 1, 2'b11, 1, 2'b11);
    apply("R7 rsv priv", 1, 1, mk(12'h001, 5'd9), 2'b10, 1, 2'b11, 1, 2'b11);
    apply("R4 S clean off", 1, 1, mk(12'h001, 5'd9), 2'b01, 0, 2'b11, 1, 2'b11);
    apply("R4 U needs s", 1, 1, mk(12'h002, 5'd9), 2'b00, 1, 2'b11, 0, 2'b11);
    apply("R7 U both", 1, 1, mk(12'h002, 5'd9), 2'b00, 1, 2'b11, 1, 2'b11);
    apply("R5 S inval off", 1, 1, mk(12'h000, 5'd4), 2'b01, 1, 2'b10, 1, 2'b11);
    apply("R6 S downgrade", 1, 1, mk(12'h000, 5'd4), 2'b01, 1, 2'b01, 1, 2'b11);
    apply("R6 U downgrade", 1, 1, mk(12'h000, 5'd4), 2'b00, 1, 2'b11, 1, 2'b01);
    apply("R9 rs1", 1, 1, mk(12'h000, 5'd21), 2'b00, 1, 2'b11, 1, 2'b11);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] sel;
      logic [31:0] w;
      int pick = $urandom_range(0, 9);
      sel = (pick < 3) ? 12'h000 : (pick < 6) ? 12'h001 : (pick < 8) ? 12'h002 : 12'($urandom);
      w = mk(sel, 5'($urandom));
      if ($urandom_range(0, 15) == 0) w = w ^ (32'h1 << $urandom_range(0, 14));
      apply((sel == 12'h000) ? "R5 R6 R7 rand" : "R1 R2 R4 R8 rand",
            $urandom_range(0, 15) != 0, $urandom_range(0, 15) != 0, w,
            2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule